// File: doc/BRIEF.md
# Codec Sample Buffer with Error Status

This block sits between an audio converter and the host side of a codec. For capture it holds one sample from the converter until the host reads it. For playback it holds one sample written by the host until the converter's next sample strobe takes it. It detects the two timing faults of this exchange: a capture overrun, where a new sample arrives before the host has collected the previous one, and a playback underrun, where the converter needs a sample that the host has not written.

The data policy is fixed. On an overrun the held capture sample is kept and the new one is dropped. On an underrun the last valid playback sample is sent again, or a zero sample is sent if the underrun-zero control is set. The two fault flags are sticky and are cleared by a status read. They are gathered into an 8-bit status word together with the per-channel overrange codes, a DMA-request summary and the calibration-busy input. An error summary output and an active-high interrupt output, gated by an enable input, let the host either poll or take an interrupt.

Top module: `smpbuf_top`

## Requirements
- R1: A converter strobe while the capture slot is full, with no host capture read in the same cycle, sets the overrun flag (status bit 0) in the following cycle. A strobe that coincides with a host read is not an overrun.
- R2: On an overrun the held capture sample stays on `cap_dout` and the incoming sample is discarded.
- R3: A converter strobe with no playback sample pending and no host write in the same cycle sets the underrun flag (status bit 1) in the following cycle. A write in the strobe cycle counts as in time, and its sample is played.
- R4: On an underrun with `zero_on_under` at 0, `play_dout` repeats the last valid playback sample.
- R5: On an underrun with `zero_on_under` at 1, `play_dout` is zero in the following cycle. The last valid sample is retained for later replays.
- R6: Status bits 0 and 1 stay set until a cycle with `stat_rd` high, and are clear in the cycle after it. An error event in the same cycle as the read leaves its flag set.
- R7: `err_any` is 1 exactly when status bit 0 or status bit 1 is 1.
- R8: `irq` is active high and equals `err_any` while `irq_en` is 1. It is 0 while `irq_en` is 0.
- R9: Status bit 3 is 1 in the cycle after `cap_req` or `play_req` is high, and 0 in the cycle after both are low.
- R10: On every converter strobe, the left overrange code is loaded into status bits 7:6 and the right code into bits 5:4. The codes are 0 (below -1.5 dB), 1 (-1.5 to 0 dB), 2 (0 to +1.5 dB) and 3 (above +1.5 dB). The fields hold between strobes.
- R11: Status bit 2 follows `cal_busy` with one cycle of delay.
- R12: After reset the status word, `err_any`, `irq`, `cap_dout` and `play_dout` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_stb | input | 1 | Converter sample strobe, one cycle per sample |
| cap_din | input | DW | Capture sample from the converter |
| play_dout | output | DW | Playback sample toward the converter |
| host_cap_rd | input | 1 | Host collects the held capture sample |
| cap_dout | output | DW | Held capture sample |
| host_play_wr | input | 1 | Host writes a playback sample |
| play_din | input | DW | Playback sample from the host |
| stat_rd | input | 1 | Host reads the status word; clears the fault flags |
| lvl_left | input | 2 | Left-channel overrange code |
| lvl_right | input | 2 | Right-channel overrange code |
| cap_req | input | 1 | Capture DMA request active |
| play_req | input | 1 | Playback DMA request active |
| cal_busy | input | 1 | Calibration in progress |
| irq_en | input | 1 | Interrupt enable |
| zero_on_under | input | 1 | Send zero instead of a replay on underrun |
| stat_word | output | 8 | Status word |
| err_any | output | 1 | OR of the two fault flags |
| irq | output | 1 | Active-high interrupt |

## Verification
Every registered result is due one clock after the edge that samples its stimulus. This covers the held capture sample, the playback output, the fault flags, the overrange fields and the request and calibration bits. `err_any` and `irq` follow combinationally from the flags and the enable. The bench drives inputs on the falling edge, steps to the next rising edge, and samples at the following falling edge, which is the first point at which the one-cycle result is valid. Gating checks on `irq` are taken after a short settle delay within the same cycle.

// File: rtl/smpbuf_pkg.sv
package smpbuf_pkg;
  localparam int STAT_W   = 8;
  localparam int LVL_W    = 2;
  localparam int B_OVR    = 0;
  localparam int B_UND    = 1;
  localparam int B_CAL    = 2;
  localparam int B_REQ    = 3;
  localparam int B_LVL_R  = 4;
  localparam int B_LVL_L  = 6;

  // sticky flag: a new event outranks the clearing read
  function automatic logic sticky_next(input logic cur, input logic evt,
                                       input logic clr);
    return evt | (cur & ~clr);
  endfunction

  // playback output on a strobe
  function automatic logic [63:0] play_pick(input logic have, input logic zero,
                                            input logic [63:0] fresh,
                                            input logic [63:0] last);
    if (have) return fresh;
    else if (zero) return '0;
    else return last;
  endfunction
endpackage

// File: rtl/smpbuf_cap_slot.sv
module smpbuf_cap_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [DW-1:0] din,
  input  logic          rd,
  output logic [DW-1:0] dout,
  output logic          ovr_evt
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          accept;

  assign accept  = stb & (~full_q | rd);
  assign ovr_evt = stb & full_q & ~rd;
  assign dout    = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        data_q <= din;
        full_q <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smpbuf_play_slot.sv
module smpbuf_play_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          wr,
  input  logic [DW-1:0] din,
  input  logic          zero_mode,
  output logic [DW-1:0] dout,
  output logic          und_evt
);
  import smpbuf_pkg::*;

  logic          pend_q;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] last_q;
  logic [DW-1:0] out_q;
  logic          have;
  logic [DW-1:0] fresh;
  logic [63:0]   pick;

  assign have    = pend_q | wr;
  assign fresh   = wr ? din : hold_q;
  assign und_evt = stb & ~have;
  assign pick    = play_pick(have, zero_mode, 64'(fresh), 64'(last_q));
  assign dout    = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      last_q <= '0;
      out_q  <= '0;
    end else if (stb) begin
      out_q  <= pick[DW-1:0];
      pend_q <= 1'b0;
      if (have) last_q <= fresh;
    end else if (wr) begin
      hold_q <= din;
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/smpbuf_status.sv
module smpbuf_status #(
  parameter int NCH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stb,
  input  logic                          ovr_evt,
  input  logic                          und_evt,
  input  logic                          clr,
  input  logic [NCH*smpbuf_pkg::LVL_W-1:0] lvl,
  input  logic                          req_any,
  input  logic                          cal,
  output logic [smpbuf_pkg::STAT_W-1:0] word,
  output logic                          err
);
  import smpbuf_pkg::*;

  logic ovr_q, und_q, req_q, cal_q;
  logic [LVL_W-1:0] lvl_q [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      und_q <= 1'b0;
      req_q <= 1'b0;
      cal_q <= 1'b0;
    end else begin
      ovr_q <= sticky_next(ovr_q, ovr_evt, clr);
      und_q <= sticky_next(und_q, und_evt, clr);
      req_q <= req_any;
      cal_q <= cal;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q[c] <= '0;
      else if (stb) lvl_q[c] <= lvl[c*LVL_W +: LVL_W];
    end
  end

  always_comb begin
    word        = '0;
    word[B_OVR] = ovr_q;
    word[B_UND] = und_q;
    word[B_CAL] = cal_q;
    word[B_REQ] = req_q;
    word[B_LVL_R +: LVL_W] = lvl_q[0];
    word[B_LVL_L +: LVL_W] = lvl_q[NCH-1];
  end

  assign err = ovr_q | und_q;
endmodule

// File: rtl/smpbuf_top.sv
module smpbuf_top #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_stb,
  input  logic [DW-1:0] cap_din,
  output logic [DW-1:0] play_dout,
  input  logic          host_cap_rd,
  output logic [DW-1:0] cap_dout,
  input  logic          host_play_wr,
  input  logic [DW-1:0] play_din,
  input  logic          stat_rd,
  input  logic [1:0]    lvl_left,
  input  logic [1:0]    lvl_right,
  input  logic          cap_req,
  input  logic          play_req,
  input  logic          cal_busy,
  input  logic          irq_en,
  input  logic          zero_on_under,
  output logic [7:0]    stat_word,
  output logic          err_any,
  output logic          irq
);
  localparam int NCH = 2;

  logic ovr_evt;
  logic und_evt;
  logic req_any;
  logic [NCH*2-1:0] lvl_bus;

  assign req_any = cap_req | play_req;
  assign lvl_bus = {lvl_left, lvl_right};

  smpbuf_cap_slot #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .stb(conv_stb), .din(cap_din),
    .rd(host_cap_rd), .dout(cap_dout), .ovr_evt(ovr_evt)
  );

  smpbuf_play_slot #(.DW(DW)) u_play (
    .clk(clk), .rst_n(rst_n), .stb(conv_stb), .wr(host_play_wr),
    .din(play_din), .zero_mode(zero_on_under), .dout(play_dout),
    .und_evt(und_evt)
  );

  smpbuf_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .stb(conv_stb), .ovr_evt(ovr_evt),
    .und_evt(und_evt), .clr(stat_rd), .lvl(lvl_bus), .req_any(req_any),
    .cal(cal_busy), .word(stat_word), .err(err_any)
  );

  assign irq = irq_en & err_any;
endmodule

// File: rtl/smpbuf_chk.sv
module smpbuf_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ovr_evt,
  input logic          und_evt,
  input logic          stat_rd,
  input logic [7:0]    stat_word,
  input logic          err_any,
  input logic          irq,
  input logic          irq_en,
  input logic          zero_on_under,
  input logic [DW-1:0] cap_dout,
  input logic [DW-1:0] play_dout
);
  a_r1_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> stat_word[0]);
  a_r2_hold_old: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(cap_dout));
  a_r3_und_sets: assert property (@(posedge clk) disable iff (!rst_n)
    und_evt |=> stat_word[1]);
  a_r5_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    (und_evt && zero_on_under) |=> (play_dout == '0));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[0] && !stat_rd) |=> stat_word[0]);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt && !und_evt) |=> (stat_word[1:0] == 2'b00));
  a_r7_err_sum: assert property (@(posedge clk) disable iff (!rst_n)
    err_any == (stat_word[0] || stat_word[1]));
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && err_any));
endmodule

bind smpbuf_top smpbuf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .und_evt(und_evt),
  .stat_rd(stat_rd), .stat_word(stat_word), .err_any(err_any), .irq(irq),
  .irq_en(irq_en), .zero_on_under(zero_on_under), .cap_dout(cap_dout),
  .play_dout(play_dout)
);

// File: tb/smpbuf_top_tb.sv
module smpbuf_top_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_stb = 1'b0;
  logic [DW-1:0] cap_din = '0;
  logic [DW-1:0] play_dout;
  logic          host_cap_rd = 1'b0;
  logic [DW-1:0] cap_dout;
  logic          host_play_wr = 1'b0;
  logic [DW-1:0] play_din = '0;
  logic          stat_rd = 1'b0;
  logic [1:0]    lvl_left = '0;
  logic [1:0]    lvl_right = '0;
  logic          cap_req = 1'b0;
  logic          play_req = 1'b0;
  logic          cal_busy = 1'b0;
  logic          irq_en = 1'b0;
  logic          zero_on_under = 1'b0;
  logic [7:0]    stat_word;
  logic          err_any;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  smpbuf_top #(.DW(DW)) u_dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs at the falling edge, advance one rising edge, return at falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    conv_stb = 0; host_cap_rd = 0; host_play_wr = 0; stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R12 status", stat_word, 0);
    chk("R12 err_any", err_any, 0);
    chk("R12 irq", irq, 0);
    chk("R12 cap_dout", cap_dout, 0);
    chk("R12 play_dout", play_dout, 0);
  endtask

  task automatic t_capture_levels();
    conv_stb = 1; cap_din = 16'h1234; lvl_left = 2; lvl_right = 1;
    host_play_wr = 1; play_din = 16'h0001;
    step();
    chk("R10 cap data", cap_dout, 16'h1234);
    chk("R10 left code", stat_word[7:6], 2);
    chk("R10 right code", stat_word[5:4], 1);
    lvl_left = 3; lvl_right = 0;
    step();
    chk("R10 fields hold between strobes", stat_word[7:4], 4'b1001);
    host_cap_rd = 1; step();
    conv_stb = 1; cap_din = 16'h5678; host_play_wr = 1; play_din = 16'h0002;
    step();
    chk("R10 refreshed codes", stat_word[7:4], 4'b1100);
    chk("R1 no overrun after read", stat_word[0], 0);
    // read and strobe together: no overrun, new sample loaded
    host_cap_rd = 1; conv_stb = 1; cap_din = 16'h9abc; host_play_wr = 1;
    step();
    chk("R1 read+strobe no overrun", stat_word[0], 0);
    chk("R1 read+strobe loads", cap_dout, 16'h9abc);
    host_cap_rd = 1; step();
  endtask

  task automatic t_overrun();
    conv_stb = 1; cap_din = 16'hc0de; host_play_wr = 1; step();
    conv_stb = 1; cap_din = 16'hdead; host_play_wr = 1; step();
    chk("R1 overrun flag", stat_word[0], 1);
    chk("R2 old sample kept", cap_dout, 16'hc0de);
    chk("R7 err_any set", err_any, 1);
    irq_en = 0; #1;
    chk("R8 irq masked", irq, 0);
    irq_en = 1; #1;
    chk("R8 irq shown", irq, 1);
    step();
    chk("R6 sticky", stat_word[0], 1);
    stat_rd = 1; step();
    chk("R6 cleared", stat_word[0], 0);
    chk("R7 err_any clear", err_any, 0);
    chk("R8 irq drops", irq, 0);
    // error in the same cycle as a status read survives
    conv_stb = 1; host_play_wr = 1; cap_din = 16'hbeef; stat_rd = 1; step();
    chk("R6 set wins over read", stat_word[0], 1);
    chk("R2 still old sample", cap_dout, 16'hc0de);
    stat_rd = 1; host_cap_rd = 1; step();
    chk("R6 cleared again", stat_word[0], 0);
    irq_en = 0;
  endtask

  task automatic t_playback();
    host_play_wr = 1; play_din = 16'h4242; step();
    conv_stb = 1; step();
    chk("R3 written sample played", play_dout, 16'h4242);
    chk("R3 no underrun", stat_word[1], 0);
    conv_stb = 1; zero_on_under = 0; step();
    chk("R3 underrun flag", stat_word[1], 1);
    chk("R4 replay last", play_dout, 16'h4242);
    chk("R7 err_any on underrun", err_any, 1);
    conv_stb = 1; zero_on_under = 1; step();
    chk("R5 zero on underrun", play_dout, 0);
    conv_stb = 1; zero_on_under = 0; step();
    chk("R5 last valid retained", play_dout, 16'h4242);
    stat_rd = 1; step();
    chk("R6 underrun cleared", stat_word[1], 0);
    conv_stb = 1; host_play_wr = 1; play_din = 16'h7777; step();
    chk("R3 write in strobe cycle played", play_dout, 16'h7777);
    chk("R3 write in strobe cycle in time", stat_word[1], 0);
    stat_rd = 1; step();
  endtask

  task automatic t_req_cal();
    cap_req = 1; step();
    chk("R9 capture request", stat_word[3], 1);
    cap_req = 0; play_req = 1; step();
    chk("R9 playback request", stat_word[3], 1);
    play_req = 0; step();
    chk("R9 none", stat_word[3], 0);
    cal_busy = 1; step();
    chk("R11 cal set", stat_word[2], 1);
    cal_busy = 0; step();
    chk("R11 cal clear", stat_word[2], 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_capture_levels();
    t_overrun();
    t_playback();
    t_req_cal();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule